// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR-style flash and turns one high-level request into the bus traffic the flash expects. A requester asks for one of four operations: write a single word, clear a sector, clear a block, or clear the whole array. The sequencer then emits the unlock and command writes on a simple synchronous flash bus and watches the device until the operation has finished.

Completion is found by reading the target word repeatedly and comparing status bit 6 between consecutive reads. Once that bit stops changing, the sequencer waits a bus recovery interval. It then reads the target word twice more and reports success only if both reads hold the value the operation should have left behind. This guards against a read that happens to land on the completion boundary. A per-class timeout, derived as twice a typical duration, ends a stuck operation with an error.

The flash bus is synchronous. A write strobe lasts one cycle and carries its address and data. A read strobe lasts one cycle, and its data is valid on `fl_rdata` during the following cycle.

Top module: `fseq_top`

## Requirements
- R1: Once reset has been released, `req_ready` is 1, and `fl_we`, `fl_re`, `done` and `err` are all 0.
- R2: A program request (`req_op`=0) produces exactly four write strobes in consecutive cycles: 5555h/00AAh, then 2AAAh/0055h, then 5555h/00A0h, then the request address with the request data.
- R3: Each erase request produces exactly six write strobes in consecutive cycles: 5555h/00AAh, 2AAAh/0055h, 5555h/0080h, 5555h/00AAh, 2AAAh/0055h, and then a final write that depends on the operation. A sector erase (`req_op`=1) ends with the request address/0030h. A block erase (`req_op`=2) ends with the request address/0050h. A chip erase (`req_op`=3) ends with 5555h/0010h.
- R4: After the last command write, the sequencer reads the request address. Consecutive poll reads are two cycles apart, and polling continues until two consecutive reads return the same bit 6.
- R5: After a matching pair of poll reads, the next read strobe comes exactly REC_CYCLES+2 cycles after the second read of the pair.
- R6: After the recovery wait, two confirmation reads are made. The expected value is the request data for a program and FFFFh for any erase. `done` is raised only if both confirmation reads equal the expected value. Any other result makes the sequencer return to polling.
- R7: If the operation has not completed, `err` is raised exactly LIMIT cycles after the first poll read strobe. LIMIT is 2×TYP_PROG for a program, 2×TYP_ERASE for a sector or block erase, and 2×TYP_CHIP for a chip erase. In the cycle `err` is high, `req_ready` is 1.
- R8: `req_ready` is 0 from the cycle after a request is accepted until `done` or `err` is raised. Requests presented while `req_ready` is 0 produce no bus activity.
- R9: `done` and `err` are single-cycle pulses and are never high together.
- R10: `fl_we` and `fl_re` are never high in the same cycle, and neither is high while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address (sector or block address for erases) |
| req_data | input | DW | Word to program |
| req_ready | output | 1 | High when idle and able to accept a request |
| done | output | 1 | One-cycle pulse on confirmed completion |
| err | output | 1 | One-cycle pulse on timeout |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe |
| fl_rdata | input | DW | Read data, valid the cycle after `fl_re` |

## Verification
The bench drives a flash model whose status bit can skip one toggle while the device is still busy. A sequencer that trusts a single matching pair of poll reads would raise `done` while the model is still busy; a correct one rejects the confirmation reads and keeps polling. The bench measures the gap from the matching pair to the next read, which catches a missing or shortened recovery wait. It times `err` against the first poll read, separately for a program and for a sector erase, which exposes a wrong limit or a limit chosen for the wrong operation class. It also presents a second request while the block is busy and confirms that no extra write strobes appear.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } fseq_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_PRD,
    S_PCAP,
    S_REC,
    S_CRD,
    S_CCAP
  } fseq_st_e;

  localparam logic [14:0] UNLOCK_A1 = 15'h5555;
  localparam logic [14:0] UNLOCK_A2 = 15'h2AAA;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERSU  = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_BLK   = 8'h50;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;

endpackage

// File: rtl/fseq_cmdgen.sv
module fseq_cmdgen
  import fseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  fseq_op_e        op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [DW-1:0]   tgt_data,
  output logic [AW-1:0]   cyc_addr,
  output logic [DW-1:0]   cyc_data,
  output logic            cyc_last
);

  localparam logic [AW-1:0] A1 = {{(AW-15){1'b0}}, UNLOCK_A1};
  localparam logic [AW-1:0] A2 = {{(AW-15){1'b0}}, UNLOCK_A2};

  logic       is_prog;
  logic [7:0] code;
  logic       use_tgt_data;

  assign is_prog = (op == OP_PROG);

  always_comb begin
    cyc_addr     = A1;
    code         = KEY_1;
    use_tgt_data = 1'b0;
    unique case (step)
      3'd0: begin cyc_addr = A1; code = KEY_1; end
      3'd1: begin cyc_addr = A2; code = KEY_2; end
      3'd2: begin cyc_addr = A1; code = is_prog ? CMD_PROG : CMD_ERSU; end
      3'd3: begin
        if (is_prog) begin
          cyc_addr     = tgt_addr;
          use_tgt_data = 1'b1;
        end else begin
          cyc_addr = A1;
          code     = KEY_1;
        end
      end
      3'd4: begin cyc_addr = A2; code = KEY_2; end
      3'd5: begin
        unique case (op)
          OP_SECT: begin cyc_addr = tgt_addr; code = CMD_SECT; end
          OP_BLK:  begin cyc_addr = tgt_addr; code = CMD_BLK;  end
          default: begin cyc_addr = A1;       code = CMD_CHIP; end
        endcase
      end
      default: begin cyc_addr = A1; code = KEY_1; end
    endcase
  end

  assign cyc_data = use_tgt_data ? tgt_data : {{(DW-8){1'b0}}, code};
  assign cyc_last = is_prog ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = en && (cnt_q == limit - 1'b1);

  // R7: an enabled counter never runs past its limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < limit));

endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int TYP_PROG   = 100,
  parameter int TYP_ERASE  = 300,
  parameter int TYP_CHIP   = 600,
  parameter int REC_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [DW-1:0] fl_rdata
);

  localparam int LIM_PROG  = 2 * TYP_PROG;
  localparam int LIM_ERASE = 2 * TYP_ERASE;
  localparam int LIM_CHIP  = 2 * TYP_CHIP;
  localparam int TW        = $clog2(LIM_CHIP + 1);
  localparam int RW        = $clog2(REC_CYCLES + 1) + 1;
  localparam int STAT_BIT  = 6;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic irst_n;
  assign irst_n = rst_s2_q;

  fseq_st_e        state_q, state_d;
  fseq_op_e        op_q, op_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   data_q, data_d;
  logic [2:0]      step_q, step_d;
  logic            prev6_q, prev6_d;
  logic            have_q, have_d;
  logic            cf_q, cf_d;
  logic            done_q, done_d;
  logic            err_q, err_d;

  logic [AW-1:0]   cg_addr;
  logic [DW-1:0]   cg_data;
  logic            cg_last;
  logic            poll_st;
  logic            to_hit, rc_hit;
  logic [TW-1:0]   lim;
  logic [DW-1:0]   expect_w;

  fseq_cmdgen #(.AW(AW), .DW(DW)) cmdgen_i (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (cg_addr),
    .cyc_data (cg_data),
    .cyc_last (cg_last)
  );

  assign poll_st = (state_q == S_PRD) || (state_q == S_PCAP) || (state_q == S_REC) ||
                   (state_q == S_CRD) || (state_q == S_CCAP);

  always_comb begin
    unique case (op_q)
      OP_PROG: lim = TW'(LIM_PROG);
      OP_CHIP: lim = TW'(LIM_CHIP);
      default: lim = TW'(LIM_ERASE);
    endcase
  end

  fseq_timer #(.W(TW)) tmo_i (
    .clk   (clk),
    .rst_n (irst_n),
    .clr   (!poll_st),
    .en    (poll_st),
    .limit (lim),
    .hit   (to_hit)
  );

  fseq_timer #(.W(RW)) rec_i (
    .clk   (clk),
    .rst_n (irst_n),
    .clr   (state_q != S_REC),
    .en    (state_q == S_REC),
    .limit (RW'(REC_CYCLES)),
    .hit   (rc_hit)
  );

  assign expect_w = (op_q == OP_PROG) ? data_q : '1;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    addr_d  = addr_q;
    data_d  = data_q;
    step_d  = step_q;
    prev6_d = prev6_q;
    have_d  = have_q;
    cf_d    = cf_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (state_q == S_IDLE) begin
      if (req_valid) begin
        op_d    = fseq_op_e'(req_op);
        addr_d  = req_addr;
        data_d  = req_data;
        step_d  = 3'd0;
        state_d = S_WR;
      end
    end else if (state_q == S_WR) begin
      if (cg_last) begin
        have_d  = 1'b0;
        state_d = S_PRD;
      end else begin
        step_d = step_q + 3'd1;
      end
    end else if (to_hit) begin
      err_d   = 1'b1;
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_PRD: state_d = S_PCAP;
        S_PCAP: begin
          if (have_q && (fl_rdata[STAT_BIT] == prev6_q)) begin
            state_d = S_REC;
          end else begin
            prev6_d = fl_rdata[STAT_BIT];
            have_d  = 1'b1;
            state_d = S_PRD;
          end
        end
        S_REC: begin
          if (rc_hit) begin
            cf_d    = 1'b0;
            state_d = S_CRD;
          end
        end
        S_CRD: state_d = S_CCAP;
        S_CCAP: begin
          if (fl_rdata != expect_w) begin
            have_d  = 1'b0;
            state_d = S_PRD;
          end else if (!cf_q) begin
            cf_d    = 1'b1;
            state_d = S_CRD;
          end else begin
            done_d  = 1'b1;
            state_d = S_IDLE;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      prev6_q <= 1'b0;
      have_q  <= 1'b0;
      cf_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      step_q  <= step_d;
      prev6_q <= prev6_d;
      have_q  <= have_d;
      cf_q    <= cf_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign fl_we     = (state_q == S_WR);
  assign fl_re     = (state_q == S_PRD) || (state_q == S_CRD);
  assign fl_addr   = fl_we ? cg_addr : addr_q;
  assign fl_wdata  = fl_we ? cg_data : '0;

  // R10: never both strobes
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!irst_n)
    !(fl_we && fl_re));
  // R9: completion outputs exclusive and single-cycle
  a_r9_onehot: assert property (@(posedge clk) disable iff (!irst_n)
    $onehot0({done, err}));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!irst_n)
    done |=> !done);
  // R8: an accepted request makes the block busy
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!irst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R7: error returns to idle
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!irst_n)
    err |-> req_ready);
  // R2: every sequence opens with the first unlock write
  a_r2_first_unlock: assert property (@(posedge clk) disable iff (!irst_n)
    (fl_we && step_q == 3'd0) |-> (fl_addr == AW'(UNLOCK_A1) && fl_wdata == DW'(KEY_1)));
  // R4: polling reads target the request address
  a_r4_read_target: assert property (@(posedge clk) disable iff (!irst_n)
    fl_re |-> (fl_addr == addr_q));
  // R6: done only follows a confirmation capture
  a_r6_done_after_cf: assert property (@(posedge clk) disable iff (!irst_n)
    $rose(done) |-> ($past(state_q) == S_CCAP));

endmodule

// File: tb/fseq_top_tb_top.sv
`timescale 1ns/1ps
module fseq_top_tb_top;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int REC = 4;
  localparam int LIM_PROG = 200;
  localparam int LIM_ERASE = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, err, fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata;

  always #4 clk = ~clk;

  fseq_top #(.AW(AW), .DW(DW), .TYP_PROG(100), .TYP_ERASE(300), .TYP_CHIP(600),
             .REC_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
    .done(done), .err(err), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // flash model configuration (written by tasks only)
  logic mdl_clr = 1'b1;
  int seq_len = 4, busy_cfg = 10, glitch_rd = -1;
  logic [DW-1:0] mem_val = '1;

  // flash model state
  int cyc = 0, wr_n = 0, rd_cnt = 0, busy_left = 0, done_cyc = -1, err_cyc = -1, viol = 0;
  bit done_busy = 0;
  logic tog = 1'b0, mb;
  logic [AW-1:0] wr_a [16];
  logic [DW-1:0] wr_d [16];
  int wr_t [16];
  int rd_t [1024];
  logic [AW-1:0] rd_a [1024];
  logic rd_b6 [1024];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if ((fl_we && fl_re) || ((fl_we || fl_re) && req_ready)) viol <= viol + 1;
    if (mdl_clr) begin
      wr_n <= 0; rd_cnt <= 0; busy_left <= 0; tog <= 1'b0;
      done_busy <= 0; done_cyc <= -1; err_cyc <= -1;
    end else begin
      if (fl_we) begin
        if (wr_n < 16) begin
          wr_a[wr_n] <= fl_addr; wr_d[wr_n] <= fl_wdata; wr_t[wr_n] <= cyc;
        end
        wr_n <= wr_n + 1;
        if (wr_n + 1 == seq_len) busy_left <= busy_cfg;
      end else if (busy_left > 0) begin
        busy_left <= busy_left - 1;
      end
      if (fl_re) begin
        if (busy_left > 0) begin
          mb = (rd_cnt == glitch_rd) ? tog : ~tog;
          tog <= mb;
          fl_rdata <= mb ? 16'h0040 : 16'h0000;
        end else begin
          mb = mem_val[6];
          fl_rdata <= mem_val;
        end
        if (rd_cnt < 1024) begin
          rd_t[rd_cnt] <= cyc; rd_a[rd_cnt] <= fl_addr; rd_b6[rd_cnt] <= mb;
        end
        rd_cnt <= rd_cnt + 1;
      end
      if (done) begin
        done_cyc <= cyc;
        if (busy_left > 0) done_busy <= 1;
      end
      if (err) err_cyc <= cyc;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int sl, input int busy, input int gl);
    @(negedge clk);
    mdl_clr = 1'b1; seq_len = sl; busy_cfg = busy; glitch_rd = gl;
    mem_val = (op == 2'd0) ? d : 16'hFFFF;
    @(negedge clk);
    mdl_clr = 1'b0;
    chk(req_ready === 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic wait_end(output bit gd, output bit ge);
    int n = 0;
    gd = 0; ge = 0;
    while (!(done || err) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    gd = done; ge = err;
    @(negedge clk);
    chk(done === 1'b0 && err === 1'b0, "R9 single-cycle completion pulse", {done, err}, 0);
  endtask

  function automatic int seq_mism(input int n, input logic [AW-1:0] ea [6], input logic [DW-1:0] ed [6]);
    int m = 0;
    for (int k = 0; k < n; k++) begin
      if (wr_a[k] !== ea[k] || wr_d[k] !== ed[k]) m++;
      if (wr_t[k] - wr_t[0] != k) m++;
    end
    return m;
  endfunction

  function automatic int rec_gap();
    for (int i = 1; i + 1 < rd_cnt && i + 1 < 1024; i++)
      if (rd_b6[i] == rd_b6[i-1]) return rd_t[i+1] - rd_t[i];
    return -1;
  endfunction

  function automatic int addr_mism(input logic [AW-1:0] a);
    int m = 0;
    for (int i = 0; i < rd_cnt && i < 1024; i++) if (rd_a[i] !== a) m++;
    return m;
  endfunction

  task automatic t_reset();
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    chk(fl_we === 1'b0 && fl_re === 1'b0, "R1 strobes idle after reset", {fl_we, fl_re}, 0);
    chk(done === 1'b0 && err === 1'b0, "R1 done/err low after reset", {done, err}, 0);
  endtask

  task automatic t_program();
    bit gd, ge;
    logic [AW-1:0] ea [6];
    logic [DW-1:0] ed [6];
    ea = '{20'h05555, 20'h02AAA, 20'h05555, 20'h12345, 0, 0};
    ed = '{16'h00AA, 16'h0055, 16'h00A0, 16'h1234, 0, 0};
    start_op(2'd0, 20'h12345, 16'h1234, 4, 40, -1);
    wait_end(gd, ge);
    chk(gd && !ge, "R6 program completes with done", {gd, ge}, 2'b10);
    chk(done_busy == 0, "R6 done not raised while busy", done_busy, 0);
    chk(wr_n == 4, "R2 program write count", wr_n, 4);
    chk(seq_mism(4, ea, ed) == 0, "R2 program write sequence", seq_mism(4, ea, ed), 0);
    chk(addr_mism(20'h12345) == 0, "R4 poll reads hit target", addr_mism(20'h12345), 0);
    chk(rd_t[1] - rd_t[0] == 2, "R4 poll read spacing", rd_t[1] - rd_t[0], 2);
    chk(rec_gap() == REC + 2, "R5 recovery gap", rec_gap(), REC + 2);
    chk(req_ready === 1'b1, "R8 ready after done", req_ready, 1);
  endtask

  task automatic t_erase(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [AW-1:0] la, input logic [DW-1:0] ld, input string nm);
    bit gd, ge;
    logic [AW-1:0] ea [6];
    logic [DW-1:0] ed [6];
    ea = '{20'h05555, 20'h02AAA, 20'h05555, 20'h05555, 20'h02AAA, la};
    ed = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, ld};
    start_op(op, a, 16'h0000, 6, 50, -1);
    wait_end(gd, ge);
    chk(gd && !ge, {"R6 erase done ", nm}, {gd, ge}, 2'b10);
    chk(wr_n == 6, {"R3 erase write count ", nm}, wr_n, 6);
    chk(seq_mism(6, ea, ed) == 0, {"R3 erase sequence ", nm}, seq_mism(6, ea, ed), 0);
    chk(done_busy == 0, {"R6 erase done after finish ", nm}, done_busy, 0);
  endtask

  task automatic t_glitch();
    bit gd, ge;
    int ng = 0;
    start_op(2'd0, 20'h00400, 16'h1234, 4, 80, 3);
    wait_end(gd, ge);
    for (int i = 1; i < rd_cnt && i < 1024; i++) if (rd_t[i] - rd_t[i-1] == REC + 2) ng++;
    chk(gd && !ge, "R6 done after spurious match", {gd, ge}, 2'b10);
    chk(done_busy == 0, "R6 spurious match rejected", done_busy, 0);
    chk(ng >= 2, "R6 polling resumed after rejection", ng, 2);
  endtask

  task automatic t_busy_ignore();
    bit gd, ge;
    start_op(2'd0, 20'h00777, 16'h0F0F, 4, 40, -1);
    repeat (8) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 20'h00001;
    repeat (10) @(negedge clk);
    chk(req_ready === 1'b0, "R8 ready low while busy", req_ready, 0);
    req_valid = 1'b0;
    wait_end(gd, ge);
    repeat (3) @(negedge clk);
    chk(wr_n == 4, "R8 request while busy ignored", wr_n, 4);
    chk(gd, "R8 busy op still completes", gd, 1);
  endtask

  task automatic t_timeout(input logic [1:0] op, input int lim, input int sl, input string nm);
    bit gd, ge;
    start_op(op, 20'h00020, 16'h5A5A, sl, 1000000, -1);
    wait_end(gd, ge);
    chk(ge && !gd, {"R7 timeout error ", nm}, {gd, ge}, 2'b01);
    chk(err_cyc - rd_t[0] == lim, {"R7 timeout cycle ", nm}, err_cyc - rd_t[0], lim);
    chk(req_ready === 1'b1, {"R7 idle after timeout ", nm}, req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl_clr = 1'b0;
    t_reset();
    t_program();
    t_erase(2'd1, 20'h0AC00, 20'h0AC00, 16'h0030, "sector");
    t_erase(2'd2, 20'h48000, 20'h48000, 16'h0050, "block");
    t_erase(2'd3, 20'h00000, 20'h05555, 16'h0010, "chip");
    t_glitch();
    t_busy_ignore();
    t_timeout(2'd0, LIM_PROG, 4, "program");
    t_timeout(2'd1, LIM_ERASE, 6, "sector");
    chk(viol == 0, "R10 strobe exclusivity and idle quiet", viol, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule